// File: doc/BRIEF.md
# Multi-Set Coefficient Bank Array

This block holds the coefficients for a pair of four-tap multiply cells and presents one coefficient to each of the eight multipliers. Each multiplier owns a bank of 32 coefficient sets of 10 bits. A processor-style write port loads one coefficient per strobe. The word it sends carries a key bit, a set field, a cell bit and a tap field.

A separate 5-bit set-select input picks the set that drives all eight multipliers at once. It may change on every clock, so a polyphase filter can rotate through its phases one cycle at a time. The eight selected coefficients leave the block as registered words, packed into one output bus.

The multipliers, the data path and any other control registers are outside this block.

Top module: `cbank_array`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every stored coefficient and the output bus to zero. After reset is released, every set reads back as zero.
- R2: When wr_en_i is high at a rising edge and wr_addr_i[8] is 1, wr_data_i is stored in the bank given by tap = wr_addr_i[1:0] and cell = wr_addr_i[2], at set wr_addr_i[7:3].
- R3: A strobed write with wr_addr_i[8] = 0 changes no stored coefficient.
- R4: When wr_en_i is low, no stored coefficient changes, whatever the address and data.
- R5: At each rising edge the output bus loads the eight coefficients of the set named by set_sel_i, so a new select is visible one cycle later.
- R6: set_sel_i may take a different value on every cycle. The output in each cycle then shows the set that was selected in the previous cycle.
- R7: If a write targets the set that is selected in the same cycle, the output first shows the old value. The new value appears on the next cycle that selects that set.
- R8: Lane k = cell*4 + tap (0 to 7) drives coef_o[10k+9:10k]. Address 0x10D therefore writes lane 5 (cell 1, tap 1) in set 1.
- R9: A write changes exactly one coefficient. All other banks and sets keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_data_i | input | 10 | Coefficient value to store |
| wr_addr_i | input | 9 | Key bit 8, set bits 7:3, cell bit 2, tap bits 1:0 |
| wr_en_i | input | 1 | Write strobe |
| set_sel_i | input | 5 | Active coefficient set for all lanes |
| coef_o | output | 80 | Eight registered 10-bit coefficients, lane k at bits 10k+9:10k |

## Verification
The assertions assume a few things about the inputs:
- rst is synchronous and is held for at least one full cycle.
- wr_en_i, wr_addr_i, wr_data_i and set_sel_i are never unknown at a rising edge.
- The read-during-write property only matters when the same set stays selected for the cycle after the write.

The bench drives every input on the falling edge and holds known values from time zero. It runs the same-set write case with the select held for two cycles, so the conditions the properties rely on actually occur.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

    // Geometry of the two multiply cells
    localparam int CELLS    = 2;
    localparam int TAPS     = 4;
    localparam int LANES    = CELLS * TAPS;
    localparam int NUM_SETS = 32;
    localparam int COEF_W   = 10;
    localparam int ADDR_W   = 9;

    // Derived field widths
    localparam int TAP_W  = $clog2(TAPS);
    localparam int CELL_W = $clog2(CELLS);
    localparam int LANE_W = TAP_W + CELL_W;
    localparam int SET_W  = $clog2(NUM_SETS);

    // Address field positions (lane index = {cell, tap})
    localparam int LANE_LSB = 0;
    localparam int SET_LSB  = LANE_W;
    localparam int KEY_BIT  = ADDR_W - 1;

endpackage

// File: rtl/cbank_wr_decode.sv
module cbank_wr_decode
    import cbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [LANES-1:0]  lane_we_o,
    output logic [SET_W-1:0]  wr_set_o
);

    logic              hit;
    logic [LANE_W-1:0] lane_idx;

    always_comb begin
        hit      = wr_en_i & wr_addr_i[KEY_BIT];
        lane_idx = wr_addr_i[LANE_LSB +: LANE_W];
        wr_set_o = wr_addr_i[SET_LSB +: SET_W];
        for (int k = 0; k < LANES; k++) begin
            lane_we_o[k] = hit && (lane_idx == LANE_W'(k));
        end
    end

    // R9
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_we_o));

    // R3
    key_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_addr_i[KEY_BIT]) |-> (lane_we_o == '0));

    // R4
    strobe_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |-> (lane_we_o == '0));

endmodule

// File: rtl/cbank_store.sv
module cbank_store
    import cbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [SET_W-1:0]  wr_set_i,
    input  logic [COEF_W-1:0] wr_data_i,
    input  logic [SET_W-1:0]  rd_set_i,
    output logic [COEF_W-1:0] coef_o
);

    logic [COEF_W-1:0] mem [NUM_SETS];
    logic [COEF_W-1:0] coef_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                mem[s] <= '0;
            end
            coef_q <= '0;
        end else begin
            if (we_i) begin
                mem[wr_set_i] <= wr_data_i;
            end
            coef_q <= mem[rd_set_i];
        end
    end

    assign coef_o = coef_q;

    // R7
    rdw_new_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && (wr_set_i == rd_set_i)) ##1 (!we_i && (rd_set_i == $past(rd_set_i)))
        |=> (coef_o == $past(wr_data_i, 2)));

endmodule

// File: rtl/cbank_array.sv
module cbank_array
    import cbank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [COEF_W-1:0]       wr_data_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic                    wr_en_i,
    input  logic [SET_W-1:0]        set_sel_i,
    output logic [LANES*COEF_W-1:0] coef_o
);

    logic [LANES-1:0] lane_we;
    logic [SET_W-1:0] wr_set;

    cbank_wr_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .lane_we_o (lane_we),
        .wr_set_o  (wr_set)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        cbank_store u_bank (
            .clk       (clk),
            .rst       (rst),
            .we_i      (lane_we[k]),
            .wr_set_i  (wr_set),
            .wr_data_i (wr_data_i),
            .rd_set_i  (set_sel_i),
            .coef_o    (coef_o[k*COEF_W +: COEF_W])
        );
    end

    // R1
    rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (coef_o == '0));

endmodule

// File: tb/cbank_array_tb.sv
module cbank_array_tb_top;
    localparam int CW    = 10;
    localparam int LANES = 8;
    localparam int SETS  = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   wr_data = '0;
    logic [8:0]      wr_addr = '0;
    logic            wr_en = 1'b0;
    logic [4:0]      set_sel = '0;
    logic [LANES*CW-1:0] coef;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [CW-1:0] model [SETS][LANES];

    always #2 clk = ~clk;

    cbank_array dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_data_i (wr_data),
        .wr_addr_i (wr_addr),
        .wr_en_i   (wr_en),
        .set_sel_i (set_sel),
        .coef_o    (coef)
    );

    task automatic check_lanes(input int s, input string req);
        bit bad = 0;
        checks++;
        for (int l = 0; l < LANES; l++) begin
            if (!bad && coef[l*CW +: CW] !== model[s][l]) begin
                bad = 1;
                $display("FAIL %s set=%0d lane=%0d got=%h exp=%h",
                         req, s, l, coef[l*CW +: CW], model[s][l]);
            end
        end
        if (bad) fails++;
    endtask

    task automatic read_set(input int s, input string req);
        @(negedge clk);
        set_sel = 5'(s);
        wr_en   = 1'b0;
        @(negedge clk);
        check_lanes(s, req);
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < SETS; s++) read_set(s, req);
    endtask

    task automatic wr(input logic [8:0] a, input logic [CW-1:0] d, input logic en);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        wr_en   = en;
        @(negedge clk);
        wr_en = 1'b0;
        if (en && a[8]) model[a[7:3]][a[2:0]] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int l = 0; l < LANES; l++) model[s][l] = '0;
        checks++;
        if (coef !== '0) begin
            fails++;
            $display("FAIL R1 output after reset got=%h exp=0", coef);
        end
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_decode();
        int sets[4] = '{0, 1, 17, 31};
        foreach (sets[i]) begin
            for (int l = 0; l < LANES; l++) begin
                wr({1'b1, 5'(sets[i]), 3'(l)}, CW'((sets[i]*37 + l*11 + 5) % 1024), 1'b1);
            end
        end
        check_all("R2");
        // R8: 0x10D -> set 1, lane 5
        wr(9'h10D, 10'h2AB, 1'b1);
        read_set(1, "R8");
        checks++;
        if (coef[5*CW +: CW] !== 10'h2AB) begin
            fails++;
            $display("FAIL R8 lane5 got=%h exp=2ab", coef[5*CW +: CW]);
        end
    endtask

    task automatic t_key();
        wr(9'h00D, 10'h155, 1'b1);  // R3: key bit clear
        read_set(1, "R3");
        check_all("R3");
    endtask

    task automatic t_strobe();
        wr(9'h10D, 10'h0F0, 1'b0);  // R4: no strobe
        read_set(1, "R4");
    endtask

    task automatic t_fast();
        int prev;
        @(negedge clk);
        wr_en   = 1'b0;
        prev    = 7;
        set_sel = 5'(prev);
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            check_lanes(prev, "R6");
            prev    = (i*13 + 7) % SETS;
            set_sel = 5'(prev);
        end
        @(negedge clk);
        check_lanes(prev, "R5");
    endtask

    task automatic t_rdw();
        @(negedge clk);
        set_sel = 5'd17;
        wr_en   = 1'b0;
        @(negedge clk);
        check_lanes(17, "R5");
        wr_addr = {1'b1, 5'd17, 3'd2};
        wr_data = 10'h3C3;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check_lanes(17, "R7");  // old value
        model[17][2] = 10'h3C3;
        @(negedge clk);
        check_lanes(17, "R7");  // new value
    endtask

    task automatic t_iso();
        wr({1'b1, 5'd31, 3'd7}, 10'h001, 1'b1);
        check_all("R9");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_decode();
        t_key();
        t_strobe();
        t_fast();
        t_rdw();
        t_iso();
        do_reset();
        check_all("R1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule